// File: doc/BRIEF.md
# Speaker Gate and Refresh Status Port

This block is a one-byte system control port that sits beside a three-channel interval timer. A host write sets two control levels. One is the gate input of timer channel 2. The other is an enable that lets the channel-2 waveform reach a speaker driver. The gates of channels 0 and 1 are not host-controlled: they are held high whenever the block is out of reset.

A host read returns a status byte made of four bits:

- the two control levels as they were last written;
- the live level of the channel-2 output;
- a refresh indicator that flips at a fixed rate, generated by a free-running divider inside the block.

The divider's terminal count is a parameter. It is chosen from the input clock so that the indicator flips about every 15 µs; at 100 MHz this is 1500 cycles. All other status bits read as zero.

Top module: `sysctl_spk_port`

## Requirements
- R1: A cycle with `wr_stb` high loads `wr_data` bit 0 into `ch2_gate`, visible from the next cycle.
- R2: A cycle with `wr_stb` high loads `wr_data` bit 1 into `spk_en`, visible from the next cycle.
- R3: Without `wr_stb`, `ch2_gate` and `spk_en` hold their values. Bits 7..2 of `wr_data` never affect any output.
- R4: A cycle with `rd_stb` high captures the status byte into `rd_data`, visible from the next cycle. In that byte, bit 0 is `ch2_gate`, bit 1 is `spk_en` and bit 5 is `ch2_out`, all as seen in the strobe cycle.
- R5: `rd_data` bit 4 carries the refresh level. That level is 0 out of reset and inverts on every REFRESH_TERM-th rising clock edge after reset release, so after m edges it equals floor(m / REFRESH_TERM) mod 2.
- R6: `rd_data` bits 7, 6, 3 and 2 are always zero.
- R7: `rd_data` holds its value in cycles without `rd_stb`. When a read and a write share a cycle, the read returns the control levels from before that write.
- R8: During and after reset, `ch0_gate` and `ch1_gate` are 1. While reset is asserted, `ch2_gate`, `spk_en` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_stb | input | 1 | Host write strobe, one per write |
| wr_data | input | 8 | Host write byte |
| rd_stb | input | 1 | Host read strobe |
| ch2_out | input | 1 | Output level of timer channel 2 |
| ch0_gate | output | 1 | Gate of timer channel 0 |
| ch1_gate | output | 1 | Gate of timer channel 1 |
| ch2_gate | output | 1 | Gate of timer channel 2 |
| spk_en | output | 1 | Speaker data enable |
| rd_data | output | 8 | Registered status byte |

## Verification
The assertions assume that the strobes are synchronous to `clk` and free of X after reset. They also assume that `ch2_out` is already synchronized, because it is sampled straight into the status byte. The bench meets these assumptions by driving every input only on the falling clock edge. It sweeps all 256 write bytes. After each write it reads back the status byte with `ch2_out` at both levels, and it predicts the refresh bit from its own count of rising edges since reset release. To expose odd divider behaviour quickly, the bench uses a short refresh term.

// File: rtl/spkport_pkg.sv
package spkport_pkg;
    localparam int BYTE_W   = 8;
    localparam int BIT_GATE = 0;
    localparam int BIT_SPK  = 1;
    localparam int BIT_RFSH = 4;
    localparam int BIT_OUT  = 5;

    typedef struct packed {
        logic gate;
        logic spk;
    } ctl_t;
endpackage

// File: rtl/spkport_refresh.sv
module spkport_refresh #(
    parameter int REFRESH_TERM = 1500
) (
    input  logic clk,
    input  logic rst_n,
    output logic rfsh
);
    localparam int CW = (REFRESH_TERM > 1) ? $clog2(REFRESH_TERM) : 1;
    localparam logic [CW-1:0] LAST = CW'(REFRESH_TERM - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.lvl = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rfsh = st_q.lvl;

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);  // R5
    AST_FLIP_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rfsh) |-> $past(st_q.cnt) == LAST);  // R5
endmodule

// File: rtl/spkport_ctrl.sv
module spkport_ctrl
    import spkport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output ctl_t              ctl
);
    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_stb) begin
            ctl_d.gate = wr_data[BIT_GATE];
            ctl_d.spk  = wr_data[BIT_SPK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    AST_WR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ctl.gate == $past(wr_data[BIT_GATE]));  // R1
    AST_WR_SPK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> ctl.spk == $past(wr_data[BIT_SPK]));  // R2
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(ctl));  // R3
endmodule

// File: rtl/spkport_rdreg.sv
module spkport_rdreg
    import spkport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  ctl_t              ctl,
    input  logic              rfsh,
    input  logic              ch2_out,
    output logic [BYTE_W-1:0] rd_data
);
    logic [BYTE_W-1:0] rd_d, rd_q, status;

    always_comb begin
        for (int i = 0; i < BYTE_W; i++) status[i] = 1'b0;
        status[BIT_GATE] = ctl.gate;
        status[BIT_SPK]  = ctl.spk;
        status[BIT_RFSH] = rfsh;
        status[BIT_OUT]  = ch2_out;
        rd_d = rd_stb ? status : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));  // R7
    AST_RD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[BIT_OUT] == $past(ch2_out));  // R4
    AST_RD_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_data[BIT_GATE] == $past(ctl.gate) && rd_data[BIT_SPK] == $past(ctl.spk));  // R4
    AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00);  // R6
endmodule

// File: rtl/sysctl_spk_port.sv
module sysctl_spk_port
    import spkport_pkg::*;
#(
    parameter int REFRESH_TERM = 1500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              ch2_out,
    output logic              ch0_gate,
    output logic              ch1_gate,
    output logic              ch2_gate,
    output logic              spk_en,
    output logic [BYTE_W-1:0] rd_data
);
    ctl_t ctl;
    logic rfsh;

    spkport_refresh #(.REFRESH_TERM(REFRESH_TERM)) i_refresh (
        .clk(clk), .rst_n(rst_n), .rfsh(rfsh)
    );

    spkport_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .ctl(ctl)
    );

    spkport_rdreg i_rdreg (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .ctl(ctl),
        .rfsh(rfsh), .ch2_out(ch2_out), .rd_data(rd_data)
    );

    assign ch0_gate = 1'b1;
    assign ch1_gate = 1'b1;
    assign ch2_gate = ctl.gate;
    assign spk_en   = ctl.spk;
endmodule

// File: tb/test_sysctl_spk_port.sv
module test_sysctl_spk_port;
    localparam int TERM = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic       ch2_out = 1'b0;
    logic       ch0_gate, ch1_gate, ch2_gate, spk_en;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int edges = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    sysctl_spk_port #(.REFRESH_TERM(TERM)) i_sysctl_spk_port (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .ch2_out(ch2_out), .ch0_gate(ch0_gate),
        .ch1_gate(ch1_gate), .ch2_gate(ch2_gate), .spk_en(spk_en),
        .rd_data(rd_data)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic rfsh_at(int m);
        return logic'((m / TERM) % 2);
    endfunction

    // status expected when strobe edge is number n (refresh after n-1 edges)
    function automatic logic [7:0] status(logic g, logic s, logic o, int n);
        logic [7:0] v = 8'h00;
        v[0] = g; v[1] = s; v[4] = rfsh_at(n - 1); v[5] = o;
        return v;
    endfunction

    task automatic do_write(logic [7:0] v);
        @(negedge clk); wr_stb = 1'b1; wr_data = v;
        @(negedge clk); wr_stb = 1'b0; wr_data = ~v;
    endtask

    task automatic do_read(logic o, output int n);
        @(negedge clk); rd_stb = 1'b1; ch2_out = o;
        @(negedge clk); rd_stb = 1'b0; n = edges;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R8 reset state
        check("R8 ch0_gate", {7'd0, ch0_gate}, 8'h01);
        check("R8 ch1_gate", {7'd0, ch1_gate}, 8'h01);
        check("R8 ch2_gate", {7'd0, ch2_gate}, 8'h00);
        check("R8 spk_en", {7'd0, spk_en}, 8'h00);
        check("R8 rd_data", rd_data, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R3 R4 R6 sweep over all write bytes
        for (int v = 0; v < 256; v++) begin
            do_write(8'(v));
            check("R1 gate", {7'd0, ch2_gate}, {7'd0, v[0]});
            check("R2 spk", {7'd0, spk_en}, {7'd0, v[1]});
            for (int o = 0; o < 2; o++) begin
                do_read(logic'(o), n);
                check("R4 R5 R6 status", rd_data, status(v[0], v[1], logic'(o), n));
            end
            check("R3 gate hold", {7'd0, ch2_gate}, {7'd0, v[0]});
            check("R3 spk hold", {7'd0, spk_en}, {7'd0, v[1]});
            check("R8 ch01", {6'd0, ch1_gate, ch0_gate}, 8'h03);
        end

        // R7 hold between strobes while inputs move
        do_read(1'b1, n);
        held = rd_data;
        @(negedge clk); ch2_out = 1'b0;
        do_write(8'h00);
        repeat (2 * TERM) @(negedge clk);
        check("R7 hold", rd_data, held);

        // R7 read and write in same cycle: pre-write levels
        do_write(8'h03);
        @(negedge clk); wr_stb = 1'b1; wr_data = 8'h00; rd_stb = 1'b1; ch2_out = 1'b0;
        @(negedge clk); wr_stb = 1'b0; rd_stb = 1'b0; n = edges;
        check("R7 same cycle", rd_data, status(1'b1, 1'b1, 1'b0, n));
        check("R1 same cycle gate", {7'd0, ch2_gate}, 8'h00);

        // R5 refresh bit over several full periods, one read per cycle
        for (int k = 0; k < 4 * TERM; k++) begin
            do_read(1'b0, n);
            check("R5 refresh", {7'd0, rd_data[4]}, {7'd0, rfsh_at(n - 1)});
        end

        // R8 reset again mid-run
        do_write(8'h03);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R8 rst ch2_gate", {7'd0, ch2_gate}, 8'h00);
        check("R8 rst spk", {7'd0, spk_en}, 8'h00);
        check("R8 rst rd", rd_data, 8'h00);
        check("R8 rst ch01", {6'd0, ch1_gate, ch0_gate}, 8'h03);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule